// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative table of page translations. Each slot holds a virtual page tag, a physical page number, an address-space number, a global flag, per-privilege-mode read and write enable masks, and separate fault-on-read and fault-on-write flags. A combinational lookup port takes a virtual page number and the current address-space number. It returns a hit flag, the index of the slot that matched, and that slot's contents.

New translations enter through an insert port. The insert always writes the slot named by a round-robin replacement pointer. A maintenance port accepts three invalidation commands: drop everything, drop every non-global entry, or drop the entries that translate one given page. An indexed read port shows the slot under the replacement pointer, and it can step that pointer without an insert. Walking page tables, checking permissions and raising faults are left to the surrounding pipeline.

The default configuration has 16 slots, 43-bit virtual addresses, 8 KB pages (so the page number is address bits 42:13), 28-bit physical page numbers, 8-bit address-space numbers and four privilege modes.

Top module: `asn_tlb`

## Requirements
- R1: A slot hits only if it is valid, its tag equals `lk_vpn`, and either its global flag is set or its stored address-space number equals `lk_asn`. On a miss, `lk_hit` is 0 and every lookup data output is 0.
- R2: When several slots hit at once, the lowest-index slot is reported on `lk_idx`, and its contents are reported on the lookup data outputs.
- R3: When `ins_en` is 1 (and the command is not flush-all), the slot at the replacement pointer is overwritten at the clock edge. Any valid entry in that slot is replaced. The new tag is `ins_vaddr[42:13]` and the slot is marked valid.
- R4: The replacement pointer advances by exactly one at each edge where `ins_en` or `rd_adv` is 1, wrapping from ENTRIES-1 to 0. It holds otherwise.
- R5: `fl_cmd`=1 (flush-all) invalidates every slot and clears its contents. It forces the pointer to 0, and it overrides an insert or advance in the same cycle.
- R6: `fl_cmd`=2 (flush-non-global) invalidates every slot whose global flag is 0. Global slots keep their contents.
- R7: `fl_cmd`=3 (flush-address) invalidates every slot whose tag equals `fl_vaddr[42:13]` and whose global flag is set or whose address-space number equals `fl_asn`. All other slots are kept. `fl_cmd`=0 does nothing.
- R8: `rd_ptr` shows the replacement pointer. `rd_valid`, `rd_tag`, `rd_ppn`, `rd_asn` and `rd_glob` show the slot at that pointer.
- R9: Inserts and flushes take effect at the clock edge, and a lookup in the same cycle sees the earlier table. When a flush-non-global or flush-address command and an insert arrive together, the flush acts on the old contents and the inserted entry survives.
- R10: After synchronous reset every slot is invalid, the pointer is 0 and `lk_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | 30 | Lookup virtual page number |
| lk_asn | input | 8 | Lookup address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | 4 | Index of the winning slot |
| lk_ppn | output | 28 | Physical page number of the hit |
| lk_glob | output | 1 | Global flag of the hit |
| lk_rd_mask | output | 4 | Per-mode read enables of the hit |
| lk_wr_mask | output | 4 | Per-mode write enables of the hit |
| lk_frd | output | 1 | Fault-on-read flag of the hit |
| lk_fwr | output | 1 | Fault-on-write flag of the hit |
| ins_en | input | 1 | Insert strobe |
| ins_vaddr | input | 43 | Virtual address of the new entry |
| ins_ppn | input | 28 | Physical page number of the new entry |
| ins_asn | input | 8 | Address-space number of the new entry |
| ins_glob | input | 1 | Global flag of the new entry |
| ins_rd_mask | input | 4 | Read enables of the new entry |
| ins_wr_mask | input | 4 | Write enables of the new entry |
| ins_frd | input | 1 | Fault-on-read flag of the new entry |
| ins_fwr | input | 1 | Fault-on-write flag of the new entry |
| fl_cmd | input | 2 | 0 none, 1 flush-all, 2 flush-non-global, 3 flush-address |
| fl_vaddr | input | 43 | Address for flush-address |
| fl_asn | input | 8 | Address-space number for flush-address |
| rd_adv | input | 1 | Step the replacement pointer |
| rd_ptr | output | 4 | Replacement pointer |
| rd_valid | output | 1 | Valid flag of the slot at the pointer |
| rd_tag | output | 30 | Tag of the slot at the pointer |
| rd_ppn | output | 28 | Physical page number of the slot at the pointer |
| rd_asn | output | 8 | Address-space number of the slot at the pointer |
| rd_glob | output | 1 | Global flag of the slot at the pointer |

## Verification
The assertions take for granted that `fl_cmd` carries one of the four defined codes each cycle, and that the maintenance and insert inputs are settled before the edge. The insert check also relies on the insert being the only writer of its slot at that edge, which holds because insert takes priority over a same-cycle flush. The stimulus drives every input at the falling edge. It draws commands only from the four legal codes and keeps page numbers and address-space numbers in narrow ranges, so that duplicate tags, cross-space global hits and flush-address matches happen often. A bench model steps in lockstep with the table to give the expected results.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W       = 43;
    localparam int PAGE_SHIFT = 13;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;
    localparam int PPN_W      = 28;
    localparam int ASN_W      = 8;
    localparam int NMODE      = 4;

    typedef enum logic [1:0] {
        FL_NONE      = 2'd0,
        FL_ALL       = 2'd1,
        FL_NONGLOBAL = 2'd2,
        FL_ADDR      = 2'd3
    } flush_e;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
        logic [ASN_W-1:0]  asn;
        logic              glob;
        logic [NMODE-1:0]  rd_mask;
        logic [NMODE-1:0]  wr_mask;
        logic              frd;
        logic              fwr;
    } pte_t;

    function automatic logic pte_hits(pte_t e, logic [VPN_W-1:0] vpn,
                                      logic [ASN_W-1:0] asn);
        return e.valid && (e.tag == vpn) && (e.glob || (e.asn == asn));
    endfunction
endpackage

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst || clear)
            ptr <= '0;
        else if (step)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !clear) |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !clear) |=> $stable(ptr));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  pte_t [ENTRIES-1:0] tbl,
    input  logic [VPN_W-1:0]   vpn,
    input  logic [ASN_W-1:0]   asn,
    output logic               hit,
    output logic [IDX_W-1:0]   idx,
    output pte_t               ent
);
    logic [ENTRIES-1:0] hv;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hv[i] = pte_hits(tbl[i], vpn, asn);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        ent = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hv[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
                ent = tbl[i];
            end
        end
    end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  flush_e             cmd,
    input  logic [VPN_W-1:0]   fl_vpn,
    input  logic [ASN_W-1:0]   fl_asn,
    input  logic               ins_en,
    input  logic [IDX_W-1:0]   ins_idx,
    input  pte_t               ins_pte,
    output pte_t [ENTRIES-1:0] tbl
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || cmd == FL_ALL)
                tbl[i] <= '0;
            else if (ins_en && ins_idx == IDX_W'(i)) begin
                tbl[i]       <= ins_pte;
                tbl[i].valid <= 1'b1;
            end else if (cmd == FL_NONGLOBAL && !tbl[i].glob)
                tbl[i].valid <= 1'b0;
            else if (cmd == FL_ADDR && pte_hits(tbl[i], fl_vpn, fl_asn))
                tbl[i].valid <= 1'b0;
        end
    end

    // checking state: remembers the last flush-address operands
    logic [VPN_W-1:0]   chk_vpn;
    logic [ASN_W-1:0]   chk_asn;
    logic [ENTRIES-1:0] any_valid, nonglob_left, addr_left;

    always_ff @(posedge clk) begin
        chk_vpn <= fl_vpn;
        chk_asn <= fl_asn;
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
        assign any_valid[i]    = tbl[i].valid;
        assign nonglob_left[i] = tbl[i].valid && !tbl[i].glob;
        assign addr_left[i]    = pte_hits(tbl[i], chk_vpn, chk_asn);
    end

    // R5
    flush_all_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == FL_ALL) |=> (any_valid == '0));

    // R6
    nonglobal_gone_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == FL_NONGLOBAL && !ins_en) |=> (nonglob_left == '0));

    // R7
    addr_gone_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == FL_ADDR && !ins_en) |=> (addr_left == '0));

    // R3
    insert_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_en && cmd != FL_ALL) |=>
            (tbl[$past(ins_idx)].valid && tbl[$past(ins_idx)].tag == $past(ins_pte.tag)));
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_glob,
    output logic [NMODE-1:0] lk_rd_mask,
    output logic [NMODE-1:0] lk_wr_mask,
    output logic             lk_frd,
    output logic             lk_fwr,
    input  logic             ins_en,
    input  logic [VA_W-1:0]  ins_vaddr,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [ASN_W-1:0] ins_asn,
    input  logic             ins_glob,
    input  logic [NMODE-1:0] ins_rd_mask,
    input  logic [NMODE-1:0] ins_wr_mask,
    input  logic             ins_frd,
    input  logic             ins_fwr,
    input  logic [1:0]       fl_cmd,
    input  logic [VA_W-1:0]  fl_vaddr,
    input  logic [ASN_W-1:0] fl_asn,
    input  logic             rd_adv,
    output logic [IDX_W-1:0] rd_ptr,
    output logic             rd_valid,
    output logic [VPN_W-1:0] rd_tag,
    output logic [PPN_W-1:0] rd_ppn,
    output logic [ASN_W-1:0] rd_asn,
    output logic             rd_glob
);
    flush_e             cmd;
    pte_t               new_pte, hit_pte, ptr_pte;
    pte_t [ENTRIES-1:0] tbl;
    logic               unused_offsets;

    assign cmd            = flush_e'(fl_cmd);
    assign unused_offsets = ^{ins_vaddr[PAGE_SHIFT-1:0], fl_vaddr[PAGE_SHIFT-1:0]};

    always_comb begin
        new_pte         = '0;
        new_pte.valid   = 1'b1;
        new_pte.tag     = ins_vaddr[VA_W-1:PAGE_SHIFT];
        new_pte.ppn     = ins_ppn;
        new_pte.asn     = ins_asn;
        new_pte.glob    = ins_glob;
        new_pte.rd_mask = ins_rd_mask;
        new_pte.wr_mask = ins_wr_mask;
        new_pte.frd     = ins_frd;
        new_pte.fwr     = ins_fwr;
    end

    tlb_rr_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .clear (cmd == FL_ALL),
        .step  (ins_en || rd_adv),
        .ptr   (rd_ptr)
    );

    tlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .fl_vpn  (fl_vaddr[VA_W-1:PAGE_SHIFT]),
        .fl_asn  (fl_asn),
        .ins_en  (ins_en),
        .ins_idx (rd_ptr),
        .ins_pte (new_pte),
        .tbl     (tbl)
    );

    tlb_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_match (
        .tbl (tbl),
        .vpn (lk_vpn),
        .asn (lk_asn),
        .hit (lk_hit),
        .idx (lk_idx),
        .ent (hit_pte)
    );

    assign lk_ppn     = hit_pte.ppn;
    assign lk_glob    = hit_pte.glob;
    assign lk_rd_mask = hit_pte.rd_mask;
    assign lk_wr_mask = hit_pte.wr_mask;
    assign lk_frd     = hit_pte.frd;
    assign lk_fwr     = hit_pte.fwr;

    assign ptr_pte  = tbl[rd_ptr];
    assign rd_valid = ptr_pte.valid;
    assign rd_tag   = ptr_pte.tag;
    assign rd_ppn   = ptr_pte.ppn;
    assign rd_asn   = ptr_pte.asn;
    assign rd_glob  = ptr_pte.glob;

    // R1
    hit_is_real_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (tbl[lk_idx].valid && tbl[lk_idx].tag == lk_vpn));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (rd_ptr == '0 && !rd_valid && !lk_hit));
endmodule

// File: tb/asn_tlb_test.sv
module asn_tlb_test;
    import tlb_pkg::*;

    localparam int N = 16;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [VPN_W-1:0] lk_vpn = '0;
    logic [ASN_W-1:0] lk_asn = '0;
    logic             lk_hit, lk_glob, lk_frd, lk_fwr;
    logic [IW-1:0]    lk_idx;
    logic [PPN_W-1:0] lk_ppn;
    logic [NMODE-1:0] lk_rd_mask, lk_wr_mask;
    logic             ins_en = 1'b0;
    logic [VA_W-1:0]  ins_vaddr = '0;
    logic [PPN_W-1:0] ins_ppn = '0;
    logic [ASN_W-1:0] ins_asn = '0;
    logic             ins_glob = 1'b0;
    logic [NMODE-1:0] ins_rd_mask = '0, ins_wr_mask = '0;
    logic             ins_frd = 1'b0, ins_fwr = 1'b0;
    logic [1:0]       fl_cmd = 2'd0;
    logic [VA_W-1:0]  fl_vaddr = '0;
    logic [ASN_W-1:0] fl_asn = '0;
    logic             rd_adv = 1'b0;
    logic [IW-1:0]    rd_ptr;
    logic             rd_valid, rd_glob;
    logic [VPN_W-1:0] rd_tag;
    logic [PPN_W-1:0] rd_ppn;
    logic [ASN_W-1:0] rd_asn;

    asn_tlb #(.ENTRIES(N)) uut (.*);

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // bench model
    logic             m_v   [N];
    logic [VPN_W-1:0] m_tag [N];
    logic [PPN_W-1:0] m_ppn [N];
    logic [ASN_W-1:0] m_asn [N];
    logic             m_g   [N];
    logic [NMODE-1:0] m_rm  [N];
    logic [NMODE-1:0] m_wm  [N];
    logic             m_fr  [N];
    logic             m_fw  [N];
    int               m_ptr;

    function automatic logic [VA_W-1:0] mkva(logic [VPN_W-1:0] vpn);
        return {vpn, 13'($urandom)};
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_tag[i] = '0; m_ppn[i] = '0; m_asn[i] = '0;
            m_g[i] = 0; m_rm[i] = '0; m_wm[i] = '0; m_fr[i] = 0; m_fw[i] = 0;
        end
        m_ptr = 0;
    endtask

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // compares outputs against the model, then steps the model and the clock
    task automatic step(string req);
        int w;
        logic [VPN_W-1:0] fv;
        w = -1;
        for (int i = N - 1; i >= 0; i--)
            if (m_v[i] && m_tag[i] == lk_vpn && (m_g[i] || m_asn[i] == lk_asn)) w = i;
        #1;
        chk(req, "lk_hit", 64'(lk_hit), 64'(w >= 0));
        if (w >= 0) begin
            chk(req, "lk_idx", 64'(lk_idx), 64'(w));
            chk(req, "lk_data", {lk_ppn, lk_glob, lk_rd_mask, lk_wr_mask, lk_frd, lk_fwr},
                {m_ppn[w], m_g[w], m_rm[w], m_wm[w], m_fr[w], m_fw[w]});
        end else
            chk(req, "lk_miss_data", {lk_ppn, lk_glob, lk_rd_mask, lk_wr_mask, lk_frd, lk_fwr}, 64'd0);
        chk(req, "rd_ptr", 64'(rd_ptr), 64'(m_ptr));
        chk(req, "rd_slot", {rd_valid, rd_tag, rd_glob}, {m_v[m_ptr], m_tag[m_ptr], m_g[m_ptr]});
        chk(req, "rd_data", {rd_ppn, rd_asn}, {m_ppn[m_ptr], m_asn[m_ptr]});
        // next state
        fv = fl_vaddr[VA_W-1:PAGE_SHIFT];
        if (fl_cmd == 2'd1) model_clear();
        else begin
            for (int i = 0; i < N; i++) begin
                if (fl_cmd == 2'd2 && !m_g[i]) m_v[i] = 0;
                if (fl_cmd == 2'd3 && m_v[i] && m_tag[i] == fv && (m_g[i] || m_asn[i] == fl_asn))
                    m_v[i] = 0;
            end
            if (ins_en) begin
                m_v[m_ptr] = 1; m_tag[m_ptr] = ins_vaddr[VA_W-1:PAGE_SHIFT];
                m_ppn[m_ptr] = ins_ppn; m_asn[m_ptr] = ins_asn; m_g[m_ptr] = ins_glob;
                m_rm[m_ptr] = ins_rd_mask; m_wm[m_ptr] = ins_wr_mask;
                m_fr[m_ptr] = ins_frd; m_fw[m_ptr] = ins_fwr;
            end
            if (ins_en || rd_adv) m_ptr = (m_ptr + 1) % N;
        end
        @(posedge clk);
        @(negedge clk);
        ins_en = 0; rd_adv = 0; fl_cmd = 2'd0;
    endtask

    task automatic put(logic [VPN_W-1:0] vpn, logic [ASN_W-1:0] asn, logic g);
        ins_en = 1; ins_vaddr = mkva(vpn); ins_asn = asn; ins_glob = g;
        ins_ppn = 28'($urandom); ins_rd_mask = 4'($urandom); ins_wr_mask = 4'($urandom);
        ins_frd = 1'($urandom); ins_fwr = 1'($urandom);
    endtask

    task automatic look(logic [VPN_W-1:0] vpn, logic [ASN_W-1:0] asn);
        lk_vpn = vpn; lk_asn = asn;
    endtask

    initial begin
        void'($urandom(32'd7321));
        model_clear();
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R10 reset state
        look(30'd0, 8'd0);
        step("R10");

        // R3 R4: fill all slots, pointer wraps back to 0
        for (int i = 0; i < N; i++) begin
            put(30'(i + 100), 8'd1, 1'b0);
            look(30'(i + 100), 8'd1);
            step("R9");   // lookup sees table before the insert
        end
        look(30'd105, 8'd1); step("R3");
        look(30'd105, 8'd1); step("R4");
        // R1 asn mismatch misses
        look(30'd105, 8'd2); step("R1");

        // R2: global copy of 105 into slot 0, duplicate tag in slot 5
        put(30'd105, 8'd9, 1'b1); step("R3");
        look(30'd105, 8'd1); step("R2");
        look(30'd105, 8'd2); step("R1");

        // R7: flush address 105 asn 1 removes both
        fl_cmd = 2'd3; fl_vaddr = mkva(30'd105); fl_asn = 8'd1;
        look(30'd105, 8'd1); step("R7");
        look(30'd105, 8'd1); step("R7");
        // R7: wrong asn on a non-global entry keeps it
        fl_cmd = 2'd3; fl_vaddr = mkva(30'd106); fl_asn = 8'd4; step("R7");
        look(30'd106, 8'd1); step("R7");

        // R6: flush non-global with a global entry present
        put(30'd200, 8'd3, 1'b1); step("R3");
        fl_cmd = 2'd2; look(30'd200, 8'd7); step("R6");
        look(30'd200, 8'd7); step("R6");
        look(30'd106, 8'd1); step("R6");

        // R9: flush non-global together with an insert keeps the insert
        put(30'd300, 8'd5, 1'b0); fl_cmd = 2'd2; step("R9");
        look(30'd300, 8'd5); step("R9");

        // R8: advance without insert
        rd_adv = 1; step("R8");
        rd_adv = 1; step("R8");
        look(30'd0, 8'd0); step("R8");

        // R5: flush-all overrides insert and advance
        put(30'd400, 8'd1, 1'b1); rd_adv = 1; fl_cmd = 2'd1; step("R5");
        look(30'd400, 8'd1); step("R5");

        // random phase
        for (int c = 0; c < 4000; c++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 45) put(30'($urandom_range(0, 11)), 8'($urandom_range(0, 3)), 1'($urandom_range(0, 3) == 0));
            if (r >= 45 && r < 52) rd_adv = 1;
            if (r >= 52 && r < 53) fl_cmd = 2'd1;
            else if (r >= 53 && r < 57) fl_cmd = 2'd2;
            else if (r >= 57 && r < 70) begin
                fl_cmd = 2'd3; fl_vaddr = mkva(30'($urandom_range(0, 11)));
                fl_asn = 8'($urandom_range(0, 3));
            end
            if (r >= 90) rd_adv = 1;
            look(30'($urandom_range(0, 11)), 8'($urandom_range(0, 3)));
            step("R1");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule